// File: doc/BRIEF.md
# Two-Wire Bus Slave with Access Status Flags

This block is the target side of a two-wire serial bus (I2C style). An external master drives the clock line and frames every transfer with START, repeated START and STOP conditions. The block only follows that clock. It never creates a bus condition of its own and has no clock generator, so there is no divider setting to program. Both bus lines pass through two-flop synchronisers and are sampled on the system clock. A START is a falling data line while the clock is high. A STOP is a rising data line while the clock is high.

After each START the block takes in seven address bits, most significant first, followed by a direction bit. If the address equals the programmed one, the block acknowledges it by pulling the data line low during the ninth clock, and it raises an access flag. For a master read, bytes come from a transmit holding register. Each byte is reloaded from that register after the master acknowledges the previous one. For a master write, each byte is acknowledged and placed in a receive holding register. The access flag drops on the next STOP or repeated START. At that point an end-of-access flag is set, and if the access was a read, a transfer-complete flag is set as well. The data line is open-drain: `sda_oe` high means drive low.

Local logic enables the block, writes the transmit register, reads the receive register and clears the sticky flags.

Top module: `i2c_slave`

## Requirements
- R1: Out of reset, `sda_oe`, `slave_acc`, `end_acc`, `tx_done` and `rx_ready` are all 0.
- R2: An address byte whose upper seven bits (first seven sent) equal `own_addr` is acknowledged: `sda_oe` is 1 during the ninth clock high. `slave_acc` becomes 1. `slave_rd` takes the eighth bit (1 = master reads, 0 = master writes).
- R3: When the address does not match, nothing is acknowledged: no ACK for the address or for any later byte. `slave_acc` stays 0 and `rx_ready` stays 0.
- R4: In a write access, every data byte is acknowledged on the ninth clock. The byte appears on `rx_data` with `rx_ready` = 1. A one-cycle `rx_rd` pulse clears `rx_ready`.
- R5: In a read access, the holding register value is shifted out MSB first. After each master ACK (data low on the ninth clock), the next byte is taken from the register's current content.
- R6: After a master NACK (data high on the ninth clock), the slave drives nothing until the next START or STOP. Further clocked bytes read as all ones.
- R7: A STOP during an access clears `slave_acc` and sets `end_acc`. `tx_done` is set only if the access was a read.
- R8: A repeated START during an access clears `slave_acc` and sets `end_acc`, and a new address is then decoded from that point.
- R9: A one-cycle `stat_clr` pulse clears `end_acc` and `tx_done`. Without a new access end, they stay 0.
- R10: While `slave_en` is 0, the bus is ignored: no acknowledge, and `slave_acc` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_en | input | 1 | Enables slave operation |
| own_addr | input | 7 | Programmed slave address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Transmit holding register write data |
| rx_rd | input | 1 | Read strobe, clears `rx_ready` |
| rx_data | output | 8 | Last byte received from the master |
| rx_ready | output | 1 | A received byte is waiting |
| slave_acc | output | 1 | Slave access in progress |
| slave_rd | output | 1 | Direction of the last matched access, 1 = master read |
| end_acc | output | 1 | Sticky: an access has ended |
| tx_done | output | 1 | Sticky: a read access has ended |
| stat_clr | input | 1 | Clears `end_acc` and `tx_done` |

## Verification
The hardest case to reach is loading the second byte of a read from a holding register that changed after the first byte had started. The bench's master model rewrites the register partway through the first byte's shift and expects the new value in the second byte. A further hard case is a repeated START that arrives right after a write byte. It must close the old access and open a read in the same frame. The bench produces this by releasing the data line during clock low and then making a fresh START. It then checks the flags between the START and the new address byte.

// File: rtl/i2c_slave.sv
module i2c_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              slave_acc,
  output logic              slave_rd,
  output logic              end_acc,
  output logic              tx_done,
  input  logic              stat_clr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } state_t;

  state_t            st;
  logic [1:0]        scl_sy, sda_sy;
  logic              scl_q, sda_q;
  logic [DATA_W-1:0] sh, thr;
  logic [CNT_W-1:0]  cnt;
  logic              mack;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr <= '0;
    else if (tx_wr) thr <= tx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sh        <= '0;
      cnt       <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      rx_data   <= '0;
      rx_ready  <= 1'b0;
      slave_acc <= 1'b0;
      slave_rd  <= 1'b0;
      end_acc   <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      if (rx_rd) rx_ready <= 1'b0;
      if (stat_clr) begin
        end_acc <= 1'b0;
        tx_done <= 1'b0;
      end
      if (!slave_en) begin
        st        <= S_IDLE;
        sda_oe    <= 1'b0;
        slave_acc <= 1'b0;
      end else if (start_c || stop_c) begin
        st     <= start_c ? S_ADDR : S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (slave_acc) begin
          slave_acc <= 1'b0;
          end_acc   <= 1'b1;
          if (slave_rd) tx_done <= 1'b1;
        end
      end else begin
        case (st)
          S_ADDR, S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == S_WDAT) begin
                rx_data  <= sh;
                rx_ready <= 1'b1;
                sda_oe   <= 1'b1;
                st       <= S_WACK;
              end else if (sh[DATA_W-1:1] == own_addr) begin
                sda_oe    <= 1'b1;
                slave_acc <= 1'b1;
                slave_rd  <= sh[0];
                st        <= S_AACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_AACK, S_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (st == S_AACK && slave_rd) begin
                sh     <= thr;
                sda_oe <= ~thr[DATA_W-1];
                st     <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WDAT;
              end
            end
          end
          S_RDAT: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                cnt    <= cnt + 1'b1;
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                sh     <= thr;
                sda_oe <= ~thr[DATA_W-1];
                st     <= S_RDAT;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

module i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_en,
  input logic scl_i,
  input logic sda_oe,
  input logic slave_acc,
  input logic slave_rd,
  input logic end_acc,
  input logic tx_done,
  input logic rx_ready
);
  // R2
  oe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> slave_acc);
  // R5
  oe_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && sda_oe != $past(sda_oe)) |-> !scl_i);
  // R7
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slave_acc) && slave_en |-> end_acc);
  // R7
  done_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> slave_rd);
  // R4
  rx_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> slave_acc && !slave_rd);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |=> !sda_oe && !slave_acc);
endmodule

bind i2c_slave i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .scl_i(scl_i),
  .sda_oe(sda_oe), .slave_acc(slave_acc), .slave_rd(slave_rd),
  .end_acc(end_acc), .tx_done(tx_done), .rx_ready(rx_ready)
);

// File: tb/tb_i2c_slave.sv
module tb_i2c_slave;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2D;

  logic clk = 0, rst_n = 0, slave_en = 0, tx_wr = 0, rx_rd = 0, stat_clr = 0;
  logic [7:0] tx_wdata = '0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, rx_ready, slave_acc, slave_rd, end_acc, tx_done;
  logic [7:0] rx_data;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .own_addr(ADDR),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_ready(rx_ready), .slave_acc(slave_acc), .slave_rd(slave_rd),
    .end_acc(end_acc), .tx_done(tx_done), .stat_clr(stat_clr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = sda_line; wq(); scl_m = 0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, input logic upd, input logic [7:0] nv,
                         output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
      if (upd && i == 4) set_thr(nv);
    end
    bit_io(~mack, s);
  endtask

  task automatic set_thr(input logic [7:0] v);
    @(negedge clk); tx_wr = 1; tx_wdata = v; @(negedge clk); tx_wr = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 sda_oe", sda_oe, 0);
    check("R1 slave_acc", slave_acc, 0);
    check("R1 end_acc", end_acc, 0);
    check("R1 tx_done", tx_done, 0);
    check("R1 rx_ready", rx_ready, 0);
  endtask

  task automatic t_write();
    logic a;
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    check("R2 addr ack", a, 1);
    check("R2 slave_acc", slave_acc, 1);
    check("R2 slave_rd write", slave_rd, 0);
    wr_byte(8'hA5, a);
    check("R4 ack byte0", a, 1);
    check("R4 rx_data byte0", rx_data, 8'hA5);
    check("R4 rx_ready", rx_ready, 1);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    check("R4 rx_ready cleared", rx_ready, 0);
    wr_byte(8'h3C, a);
    check("R4 ack byte1", a, 1);
    check("R4 rx_data byte1", rx_data, 8'h3C);
    bus_stop();
    check("R7 acc cleared", slave_acc, 0);
    check("R7 end_acc", end_acc, 1);
    check("R7 no tx_done on write", tx_done, 0);
    pulse_clr();
    check("R9 end_acc cleared", end_acc, 0);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, a);
    check("R3 no addr ack", a, 0);
    check("R3 slave_acc", slave_acc, 0);
    wr_byte(8'h77, a);
    check("R3 no data ack", a, 0);
    check("R3 rx_ready", rx_ready, 0);
    bus_stop();
    check("R3 end_acc stays 0", end_acc, 0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v;
    set_thr(8'hC3);
    bus_start();
    wr_byte({ADDR, 1'b1}, a);
    check("R2 read addr ack", a, 1);
    check("R2 slave_rd read", slave_rd, 1);
    rd_byte(1'b1, 1'b1, 8'h7E, v);
    check("R5 byte0", v, 8'hC3);
    rd_byte(1'b0, 1'b0, 8'h00, v);
    check("R5 byte1 reloaded", v, 8'h7E);
    rd_byte(1'b0, 1'b0, 8'h00, v);
    check("R6 released after nack", v, 8'hFF);
    check("R6 acc still held", slave_acc, 1);
    bus_stop();
    check("R7 acc cleared read", slave_acc, 0);
    check("R7 tx_done on read", tx_done, 1);
    check("R7 end_acc read", end_acc, 1);
    pulse_clr();
    check("R9 tx_done cleared", tx_done, 0);
    check("R9 end_acc cleared", end_acc, 0);
    repeat (20) @(negedge clk);
    check("R9 stays clear", {end_acc, tx_done}, 0);
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] v;
    set_thr(8'h5A);
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h11, a);
    check("R4 rx_data before restart", rx_data, 8'h11);
    bus_start();
    check("R8 acc cleared", slave_acc, 0);
    check("R8 end_acc", end_acc, 1);
    check("R8 no tx_done after write", tx_done, 0);
    wr_byte({ADDR, 1'b1}, a);
    check("R8 new addr ack", a, 1);
    check("R8 new access read", {slave_acc, slave_rd}, 2'b11);
    rd_byte(1'b0, 1'b0, 8'h00, v);
    check("R8 read after restart", v, 8'h5A);
    bus_stop();
    check("R8 tx_done at stop", tx_done, 1);
    pulse_clr();
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic t_disabled();
    logic a;
    slave_en = 0;
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    check("R10 no ack disabled", a, 0);
    check("R10 slave_acc", slave_acc, 0);
    wr_byte(8'h42, a);
    check("R10 rx_ready", rx_ready, 0);
    bus_stop();
    check("R10 end_acc", end_acc, 0);
    slave_en = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    slave_en = 1;
    wq();
    t_write();
    t_mismatch();
    t_read();
    t_restart();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule